// File: doc/BRIEF.md
# Half-Duplex Line Direction Arbiter

The block joins a host-side data line and a card-side data line. Both lines are open drain and pulled high when at rest. Neither side is fixed as the driver. For each transfer, the side whose line falls first becomes the master. The block copies that low onto the other side, the slave, by turning on a pull-down enable there. The block sees the lines only as sampled levels. It drives only the two pull-down enables. Level shifting and the pull-ups sit outside it. One instance serves each half-duplex line: the data line and the two auxiliary lines.

Each line level passes through a two-flop synchronizer and then a falling-edge detector. Once a master is chosen, the block stops watching the slave side. The slave's low comes from the block's own pull-down, so it cannot take ownership back. The slave pull-down turns on a fixed number of cycles after the master falls. It turns off when the master line returns high. A guard interval follows. Detection is armed again only after both lines read high. While the interface is not active, the card-side line is held low and the host side is left free.

Top module: `line_dir_arbiter`

## Requirements
- R1: During reset, and at every clock edge where `active_i` is low, the block enters an off state. In that state `card_pd_o` is 1 and `host_pd_o` is 0, whatever the line levels. Leaving the off state requires `active_i` high at a clock edge, and then both lines must read high again.
- R2: From idle, the first side whose line falls becomes master. The slave-side pull-down asserts on the (DELAY_CYC+3)-th rising clock edge after the master line falls: two synchronizer stages, one detection edge, then DELAY_CYC delay cycles. It asserts only if the master line was low when sampled three edges earlier.
- R3: The master side's own pull-down is never asserted during a transfer it owns.
- R4: If the master line stays low for L cycles, the slave pull-down is asserted for max(0, L-DELAY_CYC) cycles. It deasserts on the third rising edge after the master line returns high.
- R5: Once a transfer is owned, a falling edge on the slave line has no effect on ownership or on either pull-down.
- R6: If both lines fall in the same sampling cycle, the host side becomes master.
- R7: After a release, falling edges are ignored for GUARD_CYC cycles. They stay ignored until both lines have read high. A line that falls during the guard interval, or while the other line is still low, starts no transfer.
- R8: `host_pd_o` and `card_pd_o` are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | Interface is in active mode |
| host_line_i | input | 1 | Sampled level of the host-side line |
| card_line_i | input | 1 | Sampled level of the card-side line |
| host_pd_o | output | 1 | Pull-down enable for the host-side line |
| card_pd_o | output | 1 | Pull-down enable for the card-side line |

## Verification
The bench builds the block with DELAY_CYC=3 and GUARD_CYC=4 and the default two synchronizer stages. With these values, a sweep of master low times from 1 to 10 cycles covers, in both directions, pulses absorbed by the delay, pulses exactly at the delay, and pulses well past it. The bench computes the expected first-assert cycle and the expected pull-down length from R2 and R4. The short guard also keeps the re-arm, lockout and same-cycle cases within a few dozen cycles each.

// File: rtl/line_arb_pkg.sv
package line_arb_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_REARM,
    ST_IDLE,
    ST_WAIT,
    ST_DRIVE,
    ST_GUARD
  } arb_state_e;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } side_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // lines rest high, so reset to high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '1;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import line_arb_pkg::*;
#(
  parameter int DELAY_CYC = 3,
  parameter int GUARD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic host_lvl_i,
  input  logic card_lvl_i,
  input  logic host_fall_i,
  input  logic card_fall_i,
  output logic host_pd_o,
  output logic card_pd_o
);
  localparam int CNT_MAX = (DELAY_CYC > GUARD_CYC) ? DELAY_CYC : GUARD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] GRD_LAST = CNT_W'(GUARD_CYC - 1);

  arb_state_e       state_q, state_d;
  side_e            owner_q, owner_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             master_lvl;

  assign master_lvl = (owner_q == SIDE_HOST) ? host_lvl_i : card_lvl_i;

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_OFF:   state_d = ST_REARM;
      ST_REARM: if (host_lvl_i && card_lvl_i) state_d = ST_IDLE;
      ST_IDLE: begin
        // host checked first: wins a same-cycle tie
        if (host_fall_i) begin
          owner_d = SIDE_HOST;
          state_d = ST_WAIT;
          cnt_d   = '0;
        end else if (card_fall_i) begin
          owner_d = SIDE_CARD;
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      end
      ST_WAIT: begin
        if (master_lvl) begin
          state_d = ST_GUARD;
          cnt_d   = '0;
        end else if (cnt_q == DLY_LAST) begin
          state_d = ST_DRIVE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DRIVE: begin
        // slave line deliberately unwatched here
        if (master_lvl) begin
          state_d = ST_GUARD;
          cnt_d   = '0;
        end
      end
      ST_GUARD: begin
        if (cnt_q == GRD_LAST) state_d = ST_REARM;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_OFF;
    endcase
    if (!active_i) state_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      owner_q <= SIDE_HOST;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      cnt_q   <= cnt_d;
    end
  end

  assign host_pd_o = (state_q == ST_DRIVE) && (owner_q == SIDE_CARD);
  assign card_pd_o = (state_q == ST_OFF) ||
                     ((state_q == ST_DRIVE) && (owner_q == SIDE_HOST));
endmodule

// File: rtl/line_dir_arbiter.sv
module line_dir_arbiter #(
  parameter int DELAY_CYC   = 3,
  parameter int GUARD_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic host_line_i,
  input  logic card_line_i,
  output logic host_pd_o,
  output logic card_pd_o
);
  localparam int NUM_SIDES = 2;

  logic [NUM_SIDES-1:0] lvl_s, fall_s;

  line_sync #(.WIDTH(NUM_SIDES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({card_line_i, host_line_i}),
    .q_o    (lvl_s)
  );

  fall_detect #(.WIDTH(NUM_SIDES)) i_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_s),
    .fall_o (fall_s)
  );

  arb_fsm #(.DELAY_CYC(DELAY_CYC), .GUARD_CYC(GUARD_CYC)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active_i),
    .host_lvl_i  (lvl_s[0]),
    .card_lvl_i  (lvl_s[1]),
    .host_fall_i (fall_s[0]),
    .card_fall_i (fall_s[1]),
    .host_pd_o   (host_pd_o),
    .card_pd_o   (card_pd_o)
  );
endmodule

// File: rtl/line_dir_arbiter_chk.sv
module line_dir_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic active_i,
  input logic host_line_i,
  input logic card_line_i,
  input logic host_pd_o,
  input logic card_pd_o
);
  // R8
  excl_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_pd_o && card_pd_o));

  // R1
  inactive_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (card_pd_o && !host_pd_o));

  // R2
  host_drive_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_pd_o) |-> ($past(card_line_i, 3) == 1'b0));

  // R2
  card_drive_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(card_pd_o) && $past(active_i)) |-> ($past(host_line_i, 3) == 1'b0));
endmodule

bind line_dir_arbiter line_dir_arbiter_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active_i    (active_i),
  .host_line_i (host_line_i),
  .card_line_i (card_line_i),
  .host_pd_o   (host_pd_o),
  .card_pd_o   (card_pd_o)
);

// File: tb/test_line_dir_arbiter.sv
module test_line_dir_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 3;
  localparam int GRD        = 4;
  localparam int WDOG_CYC   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active = 1'b0;
  logic host_ext = 1'b0;  // 1: outside party pulls host line low
  logic card_ext = 1'b0;
  logic host_pd, card_pd;
  logic host_line, card_line;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign host_line = ~(host_ext | host_pd);
  assign card_line = ~(card_ext | card_pd);

  always #(CLK_PERIOD/2) clk = ~clk;

  line_dir_arbiter #(.DELAY_CYC(DLY), .GUARD_CYC(GRD)) i_line_dir_arbiter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .active_i    (active),
    .host_line_i (host_line),
    .card_line_i (card_line),
    .host_pd_o   (host_pd),
    .card_pd_o   (card_pd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // master low for len cycles; measure slave pull-down window
  task automatic pulse(input bit from_card, input bit both, input int len, input string req);
    int first = -1;
    int cnt = 0;
    int mpd = 0;
    int exp_cnt = (len > DLY) ? len - DLY : 0;
    int exp_first = (len > DLY) ? DLY + 3 : -1;
    if (from_card) card_ext = 1'b1; else host_ext = 1'b1;
    if (both) begin host_ext = 1'b1; card_ext = 1'b1; end
    for (int n = 1; n <= len + DLY + 12; n++) begin
      @(negedge clk);
      if (from_card) begin
        if (host_pd) begin cnt++; if (first < 0) first = n; end
        if (card_pd) mpd++;
      end else begin
        if (card_pd) begin cnt++; if (first < 0) first = n; end
        if (host_pd) mpd++;
      end
      if (n == len) begin host_ext = 1'b0; card_ext = 1'b0; end
    end
    check(first == exp_first, {req, " first slave pd cycle (R2)"}, first, exp_first);
    check(cnt == exp_cnt, {req, " slave pd length (R4)"}, cnt, exp_cnt);
    check(mpd == 0, {req, " master pd (R3)"}, mpd, 0);
    idle(20);
  endtask

  initial begin
    int cnt;
    int hcnt;
    // R1: reset state
    idle(3);
    check(card_pd == 1'b1, "R1 card pd in reset", card_pd, 1);
    check(host_pd == 1'b0, "R1 host pd in reset", host_pd, 0);
    rst_n = 1'b1;
    host_ext = 1'b1;
    idle(15);
    check(card_pd == 1'b1 && host_pd == 1'b0, "R1 inactive ignores host fall",
          {30'd0, host_pd, card_pd}, 1);
    host_ext = 1'b0;
    active = 1'b1;
    idle(10);
    check(card_pd == 1'b0 && host_pd == 1'b0, "R1 active idle", {30'd0, host_pd, card_pd}, 0);

    // R2 R3 R4: sweep pulse lengths, both directions
    for (int len = 1; len <= 10; len++) begin
      pulse(1'b0, 1'b0, len, "host master");
      pulse(1'b1, 1'b0, len, "card master");
    end

    // R6: same-cycle fall, host wins
    pulse(1'b0, 1'b1, 8, "R6 tie");

    // R5: slave falls during a host-owned transfer
    host_ext = 1'b1;
    cnt = 0; hcnt = 0;
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      if (card_pd) cnt++;
      if (host_pd) hcnt++;
      if (n == DLY + 1) card_ext = 1'b1;
      if (n == 10) host_ext = 1'b0;
      if (n == 12) card_ext = 1'b0;
    end
    check(cnt == 10 - DLY, "R5 slave fall keeps card pd window", cnt, 10 - DLY);
    check(hcnt == 0, "R5 slave fall never drives host", hcnt, 0);
    idle(20);

    // R7: refall during guard is ignored
    host_ext = 1'b1;
    cnt = 0;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (n == 6) host_ext = 1'b0;
      if (n == 8) host_ext = 1'b1;
      if (n == 18) host_ext = 1'b0;
      if (n > 9 && card_pd) cnt++;
    end
    check(cnt == 0, "R7 fall in guard ignored", cnt, 0);
    idle(20);

    // R7: fall while other line still low is ignored
    host_ext = 1'b1;
    card_ext = 1'b1;
    idle(6);
    host_ext = 1'b0;
    idle(GRD + 10);
    host_ext = 1'b1;
    cnt = 0; hcnt = 0;
    for (int n = 1; n <= 15; n++) begin
      @(negedge clk);
      if (card_pd) cnt++;
      if (host_pd) hcnt++;
    end
    check(cnt == 0 && hcnt == 0, "R7 no rearm while card low", cnt + hcnt, 0);
    host_ext = 1'b0;
    card_ext = 1'b0;
    idle(20);
    pulse(1'b0, 1'b0, 6, "R7 after rearm");

    // R1: active drop mid-transfer
    card_ext = 1'b1;
    idle(DLY + 5);
    check(host_pd == 1'b1, "R2 card-owned drive", host_pd, 1);
    active = 1'b0;
    @(negedge clk);
    check(host_pd == 1'b0 && card_pd == 1'b1, "R1 drop to inactive",
          {30'd0, host_pd, card_pd}, 1);
    card_ext = 1'b0;
    idle(5);
    active = 1'b1;
    idle(10);
    check(card_pd == 1'b0, "R1 reactivated idle", card_pd, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WDOG_CYC; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG_CYC, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule